// File: doc/BRIEF.md
# ARINC 429 Word Serializer

This block turns 32-bit words from a transmit queue into a serial ARINC 429 bit stream. It takes one word at a time through a valid/pop handshake and replaces bit 32 with a computed odd or even parity bit when parity insertion is on. When insertion is off it sends all 32 bits as data. The word goes out least-significant bit first, which is ARINC bit 1. Each bit is encoded as bipolar return-to-zero on two logic-level outputs meant for an external line driver. Line A is high for the first half of a one bit. Line B is high for the first half of a zero bit. Both lines are low in the second half of every bit.

Bit timing comes from a data clock. The data clock is either the system clock itself or the system clock divided by a fixed ratio. A bit time is 10 data clocks at the fast rate and 80 data clocks at the slow rate. After bit 32 the block holds both lines low for four further bit times before it accepts the next word. All per-word controls are captured when the word is taken, so changing them while a word is being sent has no effect on that word.

Top module: `a429_word_serializer`

## Requirements
- R1: While `rst_n` is low, `tx_pop`, `tx_busy`, `line_a` and `line_b` are all 0, even if `tx_valid` is 1.
- R2: `tx_pop` is 1 in exactly the cycles where the block is idle (`tx_busy` = 0) and `tx_valid` = 1. In that cycle the word and all controls are captured and `tx_busy` rises on the next clock edge.
- R3: Word bit 0 is sent first and word bit 31 last, one bit per bit time.
- R4: A bit value 1 drives `line_a` = 1, `line_b` = 0 for the first half of its bit time. A bit value 0 drives `line_a` = 0, `line_b` = 1 for that half. Both lines are 0 for the second half. The two lines are never 1 together.
- R5: With `par_en` = 1 and `par_even` = 0, the sent bit 32 makes the total count of ones among the 32 sent bits odd. Word bits 0..30 are sent unchanged.
- R6: With `par_en` = 1 and `par_even` = 1, the sent bit 32 makes that count even.
- R7: With `par_en` = 0, word bit 31 is sent unchanged as bit 32.
- R8: One half bit time lasts 5 data clocks with `speed_slow` = 0 and 40 data clocks with `speed_slow` = 1. These give bit times of 10 and 80 data clocks.
- R9: With `clk_div_en` = 0 a data clock equals one system clock. With `clk_div_en` = 1 a data clock equals DIV_RATIO system clocks (default 4).
- R10: The first half of bit 1 appears on the lines in the first cycle after the pop. This is well inside 2.5 data clocks.
- R11: After the null half of bit 32, both lines stay 0 and `tx_busy` stays 1 for exactly 4 bit times. The block then goes idle and can pop the next word in that same cycle.
- R12: Changes on `tx_word`, `par_en`, `par_even`, `clk_div_en` and `speed_slow` while `tx_busy` = 1 do not affect the word being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_word | input | 32 | Word at the head of the transmit queue |
| tx_valid | input | 1 | `tx_word` is valid |
| par_en | input | 1 | 1: bit 32 carries parity; 0: bit 32 is data |
| par_even | input | 1 | Parity sense: 0 odd, 1 even |
| clk_div_en | input | 1 | 0: data clock is the system clock; 1: divide by DIV_RATIO |
| speed_slow | input | 1 | 0: 10 data clocks per bit; 1: 80 data clocks per bit |
| tx_pop | output | 1 | Word accepted this cycle |
| tx_busy | output | 1 | A word or its trailing gap is in progress |
| line_a | output | 1 | High level for a one bit, first half only |
| line_b | output | 1 | High level for a zero bit, first half only |

## Verification
The bench sweeps all sixteen combinations of parity enable, parity sense, divider and speed. It also walks a single one through every bit position, and it compares the two lines against a bit-by-bit model in every cycle of every word. A wrong parity formula or an inverted sense shows up as a bad bit 32. A missing data-clock tick or a half-bit counter that is off by one shifts every later edge, and the per-bit window check catches the shift. The words are chained back to back. This exposes a gap counter that ends early, which pops the next word too soon, and one that ends late, which misses the pop in the idle cycle. Controls and data are scrambled while each word is in flight. A design that samples them live instead of at the pop then changes its output in the middle of the word.

// File: rtl/a429s_pkg.sv
// Package: shared types and constants of the ARINC 429 word serializer.
// Assumes a fixed 32-bit word.
package a429s_pkg;
    localparam int WORD_W = 32;
    localparam int IDX_W  = $clog2(WORD_W);

    // Sequencer phases: idle, first (marked) half, null half, inter-word gap.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MARK = 2'd1,
        ST_NULL = 2'd2,
        ST_GAP  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/a429s_clkdiv.sv
// Data-clock divider: emits a one-cycle tick per data clock.
// When div_en is 0 every system cycle is a tick. When it is 1, every
// RATIO-th cycle is a tick. The count is held at zero while run is low,
// so the first tick of a word always falls RATIO-1 cycles after the start.
// Assumes RATIO >= 2.
module a429s_clkdiv #(
    parameter int RATIO = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic div_en,
    output logic tick
);
    localparam int CW = $clog2(RATIO);
    localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (!div_en || (cnt == LAST));

    // Count system cycles within one data clock period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || !div_en) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    p_div_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    p_div_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));
endmodule

// File: rtl/a429s_half_timer.sv
// Half-bit timer: counts data-clock ticks and pulses half_done on the
// tick that ends a half bit time. The half bit is BIT_FAST/2 ticks at the
// fast rate and BIT_SLOW/2 ticks at the slow rate. Held at zero while run
// is low. Assumes even bit lengths and that slow is stable during a word.
module a429s_half_timer #(
    parameter int BIT_FAST = 10,
    parameter int BIT_SLOW = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    input  logic slow,
    output logic half_done
);
    localparam int HALF_FAST = BIT_FAST / 2;
    localparam int HALF_SLOW = BIT_SLOW / 2;
    localparam int HW = $clog2(HALF_SLOW);
    localparam logic [HW-1:0] LAST_FAST = HW'(HALF_FAST - 1);
    localparam logic [HW-1:0] LAST_SLOW = HW'(HALF_SLOW - 1);

    logic [HW-1:0] cnt;
    logic [HW-1:0] last;

    assign last      = slow ? LAST_SLOW : LAST_FAST;
    assign half_done = tick && (cnt == last);

    // Count ticks within the current half bit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (half_done) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    p_half_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= last));
    p_half_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(cnt));
endmodule

// File: rtl/a429s_framer.sv
// Framer: builds the 32-bit word to send. Bits 0..30 pass through.
// Bit 31 is either the raw data bit or a parity bit over bits 0..30 that
// makes the ones count of the whole word odd (sense 0) or even (sense 1).
// Purely combinational.
module a429s_framer
    import a429s_pkg::*;
(
    input  logic [WORD_W-1:0] data_in,
    input  logic              par_en,
    input  logic              par_even,
    output logic [WORD_W-1:0] framed
);
    logic low_xor;

    assign low_xor = ^data_in[WORD_W-2:0];

    // Choose the top bit: data or parity of the requested sense.
    always_comb begin
        framed = data_in;
        if (par_en) begin
            framed[WORD_W-1] = low_xor ^ ~par_even;
        end
    end
endmodule

// File: rtl/a429_word_serializer.sv
// ARINC 429 word serializer. Pops one word when idle, frames it, then
// sends bits 0..31 LSB first as bipolar return-to-zero on line_a/line_b.
// A trailing null gap of GAP_BITS bit times follows every word. The
// lines are decoded from registered state, so the first bit appears one
// system cycle after the pop. Assumes DIV_RATIO >= 2 and even bit lengths.
module a429_word_serializer
    import a429s_pkg::*;
#(
    parameter int DIV_RATIO = 4,
    parameter int BIT_FAST  = 10,
    parameter int BIT_SLOW  = 80,
    parameter int GAP_BITS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_valid,
    input  logic              par_en,
    input  logic              par_even,
    input  logic              clk_div_en,
    input  logic              speed_slow,
    output logic              tx_pop,
    output logic              tx_busy,
    output logic              line_a,
    output logic              line_b
);
    localparam int GAP_HALVES = 2 * GAP_BITS;
    localparam int GW = $clog2(GAP_HALVES);
    localparam logic [GW-1:0]    GAP_LAST = GW'(GAP_HALVES - 1);
    localparam logic [IDX_W-1:0] BIT_LAST = IDX_W'(WORD_W - 1);

    seq_state_t        state;
    logic [WORD_W-1:0] shreg;
    logic [IDX_W-1:0]  bit_idx;
    logic [GW-1:0]     gap_cnt;
    logic              div_q;
    logic              slow_q;
    logic              pen_q;
    logic              pev_q;
    logic [WORD_W-1:0] framed;
    logic              run;
    logic              dtick;
    logic              half_done;

    a429s_framer u_framer (
        .data_in  (tx_word),
        .par_en   (par_en),
        .par_even (par_even),
        .framed   (framed)
    );

    a429s_clkdiv #(.RATIO(DIV_RATIO)) u_clkdiv (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .div_en (div_q),
        .tick   (dtick)
    );

    a429s_half_timer #(.BIT_FAST(BIT_FAST), .BIT_SLOW(BIT_SLOW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .tick      (dtick),
        .slow      (slow_q),
        .half_done (half_done)
    );

    assign run     = (state != ST_IDLE);
    assign tx_busy = run;
    assign tx_pop  = rst_n && (state == ST_IDLE) && tx_valid;
    assign line_a  = (state == ST_MARK) && shreg[0];
    assign line_b  = (state == ST_MARK) && !shreg[0];

    // Sequence each word: capture, bit halves, then the null gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            shreg   <= '0;
            bit_idx <= '0;
            gap_cnt <= '0;
            div_q   <= 1'b0;
            slow_q  <= 1'b0;
            pen_q   <= 1'b0;
            pev_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (tx_valid) begin
                        shreg   <= framed;
                        bit_idx <= '0;
                        div_q   <= clk_div_en;
                        slow_q  <= speed_slow;
                        pen_q   <= par_en;
                        pev_q   <= par_even;
                        state   <= ST_MARK;
                    end
                end
                ST_MARK: begin
                    if (half_done) begin
                        state <= ST_NULL;
                    end
                end
                ST_NULL: begin
                    if (half_done) begin
                        if (bit_idx == BIT_LAST) begin
                            gap_cnt <= '0;
                            state   <= ST_GAP;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                            shreg   <= shreg >> 1;
                            state   <= ST_MARK;
                        end
                    end
                end
                ST_GAP: begin
                    if (half_done) begin
                        if (gap_cnt == GAP_LAST) begin
                            state <= ST_IDLE;
                        end else begin
                            gap_cnt <= gap_cnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_lines_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_a && line_b));
    p_null_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NULL) |-> (!line_a && !line_b));
    p_pop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_busy);
    p_first_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |=> (tx_busy && (line_a || line_b)));
    p_parity_odd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_MARK) && (bit_idx == '0) && pen_q && !pev_q)
            |-> ($countones(shreg) % 2 == 1));
    p_parity_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_MARK) && (bit_idx == '0) && pen_q && pev_q)
            |-> ($countones(shreg) % 2 == 0));
    p_gap_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP) |-> (!line_a && !line_b && !tx_pop && tx_busy));
    p_cfg_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && $past(tx_busy)) |-> ($stable(slow_q) && $stable(div_q)));
endmodule

// File: tb/sim_a429_word_serializer.sv
module sim_a429_word_serializer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] tx_word = '0;
    logic        tx_valid = 1'b0;
    logic        par_en = 1'b0;
    logic        par_even = 1'b0;
    logic        clk_div_en = 1'b0;
    logic        speed_slow = 1'b0;
    logic        tx_pop;
    logic        tx_busy;
    logic        line_a;
    logic        line_b;

    int n_cmp = 0;
    int n_bad = 0;
    bit pending = 1'b0;

    always #2 clk = ~clk;

    a429_word_serializer u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_word    (tx_word),
        .tx_valid   (tx_valid),
        .par_en     (par_en),
        .par_even   (par_even),
        .clk_div_en (clk_div_en),
        .speed_slow (speed_slow),
        .tx_pop     (tx_pop),
        .tx_busy    (tx_busy),
        .line_a     (line_a),
        .line_b     (line_b)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pattern(input int k);
        return 32'hA5C3_0F96 ^ (32'(k) * 32'h1357_9BDF);
    endfunction

    // Send one word and compare every cycle of it plus its trailing gap.
    task automatic run_word(input logic [31:0] d, input bit pen, input bit pev,
                            input bit dv, input bit sp, input bit chain,
                            input logic [31:0] nd, input bit npen, input bit npev,
                            input bit ndv, input bit nsp);
        int t;
        int bad;
        logic [31:0] w;
        logic [1:0] act;
        logic [1:0] exp;
        logic [1:0] first_act;
        logic [1:0] first_exp;
        string tag;
        t = (sp ? 40 : 5) * (dv ? 4 : 1);
        w = d;
        if (pen) w[31] = pev ? ($countones(d[30:0]) % 2 == 1)
                             : ($countones(d[30:0]) % 2 == 0);
        if (!pending) begin
            @(negedge clk);
            tx_word = d; par_en = pen; par_even = pev;
            clk_div_en = dv; speed_slow = sp; tx_valid = 1'b1;
            #1;
        end
        check(tx_pop && !tx_busy, "R2 pop when idle", {tx_pop, tx_busy}, 2'b10);
        @(posedge clk);
        @(negedge clk);
        check(!tx_pop && tx_busy && (line_a || line_b), "R10 first bit next cycle",
              {tx_pop, tx_busy, line_a, line_b}, {2'b01, w[0], !w[0]});
        // R12: scramble every input while the word is in flight
        tx_valid = 1'b0; tx_word = ~d; par_en = ~pen; par_even = ~pev;
        clk_div_en = ~dv; speed_slow = ~sp;
        bad = 0; first_act = '0; first_exp = '0;
        for (int s = 1; s <= 64 * t; s++) begin
            int i;
            int c;
            if (s > 1) @(negedge clk);
            i = (s - 1) / (2 * t);
            c = (s - 1) % (2 * t);
            act = {line_a, line_b};
            exp = (c < t) ? {w[i], !w[i]} : 2'b00;
            if (act !== exp && bad == 0) begin
                first_act = act; first_exp = exp;
            end
            if (act !== exp) bad++;
            if (c == 2 * t - 1) begin
                if (i == 31) tag = pen ? (pev ? "R6 even parity bit" : "R5 odd parity bit")
                                       : "R7 raw bit 32";
                else if (sp) tag = "R8 R12 slow bit window";
                else if (dv) tag = "R9 R12 divided bit window";
                else tag = "R3 R4 bit order and shape";
                check(bad == 0, $sformatf("%s (bit %0d)", tag, i + 1), first_act, first_exp);
                bad = 0;
            end
        end
        bad = 0;
        for (int s = 64 * t + 1; s <= 72 * t; s++) begin
            @(negedge clk);
            if (line_a || line_b || !tx_busy || tx_pop) bad++;
            if (s == 64 * t + 1 && chain) begin
                tx_word = nd; par_en = npen; par_even = npev;
                clk_div_en = ndv; speed_slow = nsp; tx_valid = 1'b1;
            end
        end
        check(bad == 0, "R11 null gap of four bit times", 64'(bad), 64'd0);
        @(negedge clk);
        check(!tx_busy && (tx_pop == chain), "R11 idle right after gap",
              {tx_busy, tx_pop}, {1'b0, chain});
        pending = chain;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        tx_valid = 1'b1;
        repeat (3) @(negedge clk);
        check({tx_pop, tx_busy, line_a, line_b} == 4'b0, "R1 reset outputs",
              {tx_pop, tx_busy, line_a, line_b}, 4'b0);
        @(negedge clk);
        tx_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check({tx_pop, tx_busy, line_a, line_b} == 4'b0, "R1 idle after reset",
              {tx_pop, tx_busy, line_a, line_b}, 4'b0);

        // Full sweep of the four controls, words chained back to back.
        for (int k = 0; k < 16; k++) begin
            logic [3:0] c;
            logic [3:0] n;
            c = 4'(k);
            n = 4'(k + 1);
            run_word(pattern(k), c[0], c[1], c[2], c[3], k != 15,
                     pattern(k + 1), n[0], n[1], n[2], n[3]);
        end

        // Walking one through each bit position, fast and undivided.
        for (int k = 0; k < 32; k++) begin
            logic [1:0] m;
            m = 2'(k);
            run_word(32'h1 << k, m[0], m[1], 1'b0, 1'b0, 1'b0,
                     '0, 1'b0, 1'b0, 1'b0, 1'b0);
        end

        // Extremes of the parity computation.
        run_word(32'h0000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, '0, 0, 0, 0, 0);
        run_word(32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, 0, 0, 0, 0);
        run_word(32'h7FFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, 0, 0, 0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule